// File: doc/BRIEF.md
# Right-Justified Serial Audio Receiver

This block takes stereo PCM from a three-wire serial link (bit clock, serial data, word clock) and turns each channel slot into a parallel sample in the system clock domain. Words are two's complement, MSB first, and aligned to the end of their slot. Whatever precedes the last N bits of a slot is padding and is thrown away. N is 16 or 18 and is chosen by a select pin.

The bit clock and the word clock come in as ordinary inputs, so they are not used as clocks here. Both run through a synchronizer into the system clock domain. A rising edge of the synchronized bit clock marks one serial bit. The data line and the word-clock level are taken only at those edges. A change of the word-clock level marks the end of a slot. At that point the receiver presents the finished word together with its channel flag and raises a one-cycle strobe. A 16-bit word is sign-extended to the 18-bit output.

Top module: `rj_audio_rx`

## Requirements
- R1: While rst_n is low at a clock edge, smp_valid, smp_right and smp_data are all zero after that edge.
- R2: With a word length of 16, the output holds the 16 bits sampled at the last 16 bit-clock rising edges before the word-clock change. Output bits 17 and 16 are copies of bit 15.
- R3: With a word length of 18, the output holds the 18 bits sampled at the last 18 bit-clock rising edges before the word-clock change. The first bit received is the MSB.
- R4: Bits of a slot that come before its last N bits have no effect on the output word.
- R5: A slot in which the word clock is high is the left channel and is reported with smp_right = 0. A slot in which it is low is the right channel and is reported with smp_right = 1.
- R6: smp_valid is high for exactly one clock cycle. It rises 3 system clock cycles after the rising bit-clock edge at which the new word-clock level is first present.
- R7: Slots of 16, 24 and 32 bit-clock periods each produce one sample per slot. These correspond to 32, 48 and 64 bit clocks per sample period. 16-bit slots are used only with 16-bit words.
- R8: The word length is taken from wlen18_sel (0 = 16 bits, 1 = 18 bits) only while reset is applied. A later change of wlen18_sel has no effect until the next reset.
- R9: smp_data does not change in cycles where smp_valid is low.
- R10: Changes on sdata_in or wclk_in while the bit clock is high have no effect on the captured words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wlen18_sel | input | 1 | Word length select, sampled during reset: 0 = 16 bits, 1 = 18 bits |
| bclk_in | input | 1 | Serial bit clock, sampled by clk |
| wclk_in | input | 1 | Word clock: high = left slot, low = right slot |
| sdata_in | input | 1 | Serial data, MSB first |
| smp_data | output | 18 | Captured sample, sign-extended when the word length is 16 |
| smp_right | output | 1 | Channel of the current sample: 1 = right, 0 = left |
| smp_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
Each sample is due exactly three system clock cycles after the rising bit-clock edge that carries the first bit of the following slot. Two of those cycles are the synchronizer and one is the output register. The bench records the cycle number at which it raises that bit-clock edge. At every falling clock edge where the strobe is high, it checks that exactly three cycles have passed and compares the word and channel with the oldest pending expectation. In strobe-free cycles it checks that the held word stays unchanged. At the end of each phase it checks that the number of strobes equals the number of slots.

// File: rtl/rj_rx_pkg.sv
// Package: shared widths and types for the right-justified receiver.
// Assumes the longest word is 18 bits and the short word is 16 bits.
package rj_rx_pkg;
    localparam int LONG_W   = 18;
    localparam int SHORT_W  = 16;
    localparam int EXT_W    = LONG_W - SHORT_W;
    localparam int SYNC_LEN = 2;

    typedef logic [LONG_W-1:0] sample_t;

    // Sign-extend the low SHORT_W bits of a word to LONG_W bits.
    function automatic sample_t sext_short(input sample_t w);
        return {{EXT_W{w[SHORT_W-1]}}, w[SHORT_W-1:0]};
    endfunction
endpackage

// File: rtl/rj_sync_chain.sv
// Module: multi-stage synchronizer for a vector of asynchronous levels.
// Assumes every bit is a slow level; each bit is synchronized on its own.
module rj_sync_chain #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: move the levels one stage further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pipe[s] <= '0;
                else if (s == 0)
                    pipe[s] <= d;
                else
                    pipe[s] <= pipe[(s > 0) ? s - 1 : 0];
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/rj_rise_detect.sv
// Module: one-cycle pulse on a rising edge of a synchronized level.
// Assumes the input is already in the clk domain.
module rj_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_d;

    // Purpose: remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_d <= 1'b0;
        else
            level_d <= level;
    end

    assign rise = level & ~level_d;
endmodule

// File: rtl/rj_slot_capture.sv
// Module: shifts serial bits on each bit tick and emits a word when the word
// clock level changes.
// Assumes bit_tick is a single-cycle pulse, and that data_bit and word_lvl
// are valid in the cycle where bit_tick is high.
// The word length is frozen at reset.
module rj_slot_capture
    import rj_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wlen18_sel,
    input  logic    bit_tick,
    input  logic    data_bit,
    input  logic    word_lvl,
    output sample_t smp_data,
    output logic    smp_right,
    output logic    smp_valid,
    output logic    len18_q
);
    sample_t shreg;
    logic    word_q;
    logic    armed;
    logic    slot_end;
    sample_t word_sel;

    assign slot_end = bit_tick & armed & (word_lvl != word_q);

    generate
        if (LONG_W > SHORT_W) begin : g_ext
            assign word_sel = len18_q ? shreg : sext_short(shreg);
        end else begin : g_noext
            assign word_sel = shreg;
        end
    endgenerate

    // Purpose: shift the history, track the slot level, and publish words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            word_q    <= 1'b0;
            armed     <= 1'b0;
            len18_q   <= wlen18_sel;
            smp_data  <= '0;
            smp_right <= 1'b0;
            smp_valid <= 1'b0;
        end else begin
            smp_valid <= 1'b0;
            if (bit_tick) begin
                shreg  <= {shreg[LONG_W-2:0], data_bit};
                word_q <= word_lvl;
                armed  <= 1'b1;
            end
            if (slot_end) begin
                smp_valid <= 1'b1;
                smp_right <= ~word_q;
                smp_data  <= word_sel;
            end
        end
    end
endmodule

// File: rtl/rj_audio_rx.sv
// Module: top of the right-justified serial audio receiver.
// Assumes bclk_in stays high and low for at least two clk cycles each.
module rj_audio_rx
    import rj_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wlen18_sel,
    input  logic              bclk_in,
    input  logic              wclk_in,
    input  logic              sdata_in,
    output logic [LONG_W-1:0] smp_data,
    output logic              smp_right,
    output logic              smp_valid
);
    logic [2:0] raw_vec;
    logic [2:0] sync_vec;
    logic       bit_tick;
    logic       len18_q;

    assign raw_vec = {bclk_in, wclk_in, sdata_in};

    rj_sync_chain #(.WIDTH(3), .STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_vec),
        .q     (sync_vec)
    );

    rj_rise_detect u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sync_vec[2]),
        .rise  (bit_tick)
    );

    rj_slot_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .wlen18_sel (wlen18_sel),
        .bit_tick   (bit_tick),
        .data_bit   (sync_vec[0]),
        .word_lvl   (sync_vec[1]),
        .smp_data   (smp_data),
        .smp_right  (smp_right),
        .smp_valid  (smp_valid),
        .len18_q    (len18_q)
    );
endmodule

// File: rtl/rj_audio_rx_chk.sv
// Module: property checker for rj_audio_rx, bound to the top.
module rj_audio_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        smp_valid,
    input logic [17:0] smp_data,
    input logic        len18
);
    // R6
    valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !smp_valid);

    // R2
    short_sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !len18) |-> (smp_data[17:15] == 3'b000 || smp_data[17:15] == 3'b111));

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |-> $stable(smp_data));

    // R8
    len_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(len18));
endmodule

bind rj_audio_rx rj_audio_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .len18     (len18_q)
);

// File: tb/rj_audio_rx_tb_top.sv
// Bench: drives serial frames at several slot lengths and compares each word.
module rj_audio_rx_tb_top;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wlen18_sel = 1'b0;
    logic        bclk_in = 1'b0;
    logic        wclk_in = 1'b1;
    logic        sdata_in = 1'b0;
    logic [17:0] smp_data;
    logic        smp_right;
    logic        smp_valid;

    int unsigned cyc = 0;
    int          checks = 0;
    int          fails = 0;
    int          trans_cyc = 0;
    logic        prev_w = 1'b1;
    logic        started = 1'b0;
    logic        mon_on = 1'b0;
    logic [17:0] exp_data [0:255];
    logic        exp_right [0:255];
    int          wr_ptr = 0;
    int          rd_ptr = 0;
    logic [17:0] held = '0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    rj_audio_rx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wlen18_sel (wlen18_sel),
        .bclk_in    (bclk_in),
        .wclk_in    (wclk_in),
        .sdata_in   (sdata_in),
        .smp_data   (smp_data),
        .smp_right  (smp_right),
        .smp_valid  (smp_valid)
    );

    function automatic logic [17:0] exp_word(input logic [17:0] v, input logic long_mode);
        return long_mode ? v : {{2{v[15]}}, v[15:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Monitor: compare every strobe with the next expectation (R2 R3 R4 R5 R6 R9 R10).
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (smp_valid) begin
                check(cyc - trans_cyc == 3, "R6 latency", cyc - trans_cyc, 3);
                if (rd_ptr < wr_ptr) begin
                    check(smp_data == exp_data[rd_ptr], "R2/R3/R4/R10 word", smp_data, exp_data[rd_ptr]);
                    check(smp_right == exp_right[rd_ptr], "R5 channel", smp_right, exp_right[rd_ptr]);
                    rd_ptr++;
                end else begin
                    check(1'b0, "R7 unexpected strobe", 1, 0);
                end
                held = smp_data;
            end else begin
                check(smp_data == held, "R9 hold", smp_data, held);
            end
        end
    end

    task automatic do_reset(input logic sel);
        @(negedge clk);
        rst_n = 1'b0;
        wlen18_sel = sel;
        bclk_in = 1'b0;
        wclk_in = 1'b1;
        prev_w = 1'b1;
        started = 1'b0;
        mon_on = 1'b0;
        repeat (5) @(negedge clk);
        check(smp_valid == 1'b0 && smp_right == 1'b0 && smp_data == '0, "R1 reset", {smp_valid, smp_right, smp_data}, 0);
        rst_n = 1'b1;
        wr_ptr = 0;
        rd_ptr = 0;
        held = '0;
        mon_on = 1'b1;
    endtask

    task automatic send_bit(input logic b, input logic w, input bit glitch);
        @(negedge clk);
        bclk_in = 1'b0;
        sdata_in = b;
        wclk_in = w;
        repeat (HALF - 1) @(negedge clk);
        @(negedge clk);
        bclk_in = 1'b1;
        if (started && w != prev_w) trans_cyc = cyc;
        prev_w = w;
        started = 1'b1;
        repeat (3) @(negedge clk);
        if (glitch) begin
            sdata_in = ~sdata_in;
            wclk_in = ~wclk_in;
        end
        repeat (HALF - 3) @(negedge clk);
    endtask

    task automatic send_slot(input logic w, input int slot_bits, input logic [17:0] v,
                             input int nsend, input logic long_exp, input bit glitch);
        for (int i = slot_bits - 1; i >= 0; i--) begin
            logic b;
            b = (i < nsend) ? v[i] : 1'($urandom);
            send_bit(b, w, glitch);
        end
        exp_data[wr_ptr] = exp_word(v, long_exp);
        exp_right[wr_ptr] = ~w;
        wr_ptr++;
    endtask

    // Runs frames, then a flush bit, then checks the strobe count (R7).
    task automatic run_phase(input int slot_bits, input int frames, input int nsend,
                             input logic long_exp, input bit glitch,
                             input logic [17:0] d0, input logic [17:0] d1);
        for (int f = 0; f < frames; f++) begin
            logic [17:0] vl, vr;
            vl = (f == 0) ? d0 : 18'($urandom);
            vr = (f == 0) ? d1 : 18'($urandom);
            send_slot(1'b1, slot_bits, vl, nsend, long_exp, glitch);
            send_slot(1'b0, slot_bits, vr, nsend, long_exp, glitch);
        end
        send_bit(1'b0, 1'b1, 1'b0);
        repeat (8) @(negedge clk);
        check(rd_ptr == wr_ptr, "R7 sample count", rd_ptr, wr_ptr);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        // R2 and R7 at 32, 48 and 64 bit clocks per sample
        do_reset(1'b0);
        run_phase(16, 8, 16, 1'b0, 1'b0, 18'h08000, 18'h07fff);
        do_reset(1'b0);
        run_phase(24, 8, 16, 1'b0, 1'b0, 18'h0ffff, 18'h00000);
        // R4 and R10: garbage leading bits, glitches while the bit clock is high
        do_reset(1'b0);
        run_phase(32, 8, 16, 1'b0, 1'b1, 18'h00001, 18'h18000);
        // R8: select raised after reset, so 16-bit handling stays
        do_reset(1'b0);
        @(negedge clk);
        wlen18_sel = 1'b1;
        run_phase(32, 6, 18, 1'b0, 1'b0, 18'h2a5a5, 18'h15a5a);
        // R3: 18-bit words after a reset with the select high
        do_reset(1'b1);
        run_phase(24, 8, 18, 1'b1, 1'b0, 18'h20000, 18'h1ffff);
        do_reset(1'b1);
        run_phase(32, 8, 18, 1'b1, 1'b1, 18'h3ffff, 18'h00001);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=finished", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule